// File: doc/BRIEF.md
# Serial Grayscale and Control Loader for a 48-Channel LED Driver

This block is the serial input side of a 48-channel grayscale LED driver. A host drives a data line and a shift clock; each shift clock rising edge pushes one bit into a 48-bit shift register. The top bit of that register is driven out again, so several drivers can sit on one chain and each passes data on to the next. All three serial inputs are sampled in the block's own clock domain. Edges are detected there, so the host's shift clock must stay below half the system clock.

A separate latch strobe tells the block what to do with the word now in the register. The block counts the shift clock rising edges seen while the strobe is high and acts on that count when the strobe falls. The word can go into the next 48-bit group of a 768-bit grayscale staging store. It can go into the same store and then publish the whole store to the display latch. It can also go into a 48-bit function-control register. The staging store holds 16 groups of 48 bits, which is one 16-bit grayscale value per channel. An address counter picks the group that the next write fills.

Top module: `led_serial_front`

## Requirements
- R1: After reset `sout` is 0, `disp_data` is all zeros and the address counter points at group 0. `fc_word` holds its default: bits [2:0] = 3'd4 (global brightness), bits [11:3], [20:12] and [29:21] = 9'h100 each (three colour-group levels), and bits [47:30] = 0.
- R2: On each rising edge of `sclk`, the bit on `sin` enters bit 0 of the shift register and every other bit moves one place toward bit 47.
- R3: `sout` always equals bit 47 of the shift register. A bit shifted in therefore appears on `sout` after 48 rising edges.
- R4: The number of `sclk` rising edges seen while `lat` is high selects the command, which takes effect when `lat` falls. The counter saturates at 15.
- R5: A count of 1 writes the shift register into the staging group selected by the address counter, with group g occupying staging bits [48g+47:48g]. The counter then advances by one and wraps from group 15 to group 0.
- R6: A count of 3 writes the register into the current group, then copies the whole staging store to `disp_data` (bit i of the staging store to bit i of `disp_data`). It also returns the address counter to group 0.
- R7: A count of 7 (line reset) has exactly the effect of a count of 3.
- R8: A count of 5 loads the shift register into `fc_word`. It leaves the staging store and the address counter unchanged.
- R9: Any other count, including a `lat` pulse with no `sclk` edges, changes neither `fc_word`, `disp_data` nor the address counter.
- R10: `disp_data` changes only on a count of 3 or 7. Group writes alone leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock from the host |
| sin | input | 1 | Serial data in |
| lat | input | 1 | Latch strobe; edge count while high selects the command |
| sout | output | 1 | Serial data out, top bit of the shift register |
| disp_data | output | 768 | Display latch, 16-bit grayscale for 48 channels |
| fc_word | output | 48 | Function-control register |

## Verification
A full line is built from fifteen single-edge writes and closed by a three-edge publish. Each group carries a distinct pattern, so a misplaced group or a wrong address step shows up in the 768-bit compare. The display is checked before the publish to show that the write path and the display path are separate. A second line writes seventeen groups and closes with a line reset; this proves that the counter wraps and that the seventh-edge code behaves like the third. Counts of 0, 2, 4, 6 and 9 are sent between known states, and a five-edge control load is checked against both outputs. Together these show that only the four defined counts act, and that the address counter does not move on the others.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  localparam int LSF_CNT_W = 4;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_GS_WRITE,
    CMD_GS_PUBLISH,
    CMD_FC_WRITE,
    CMD_LINE_RESET
  } lsf_cmd_e;

  // Map an edge count seen while the strobe is high to a command.
  function automatic lsf_cmd_e lsf_decode(input logic [LSF_CNT_W-1:0] edges);
    case (edges)
      4'd1:    return CMD_GS_WRITE;
      4'd3:    return CMD_GS_PUBLISH;
      4'd5:    return CMD_FC_WRITE;
      4'd7:    return CMD_LINE_RESET;
      default: return CMD_NONE;
    endcase
  endfunction

  // Power-on value of the control word.
  function automatic logic [47:0] lsf_fc_default();
    logic [47:0] w;
    w        = '0;
    w[2:0]   = 3'd4;
    w[11:3]  = 9'h100;
    w[20:12] = 9'h100;
    w[29:21] = 9'h100;
    return w;
  endfunction

endpackage

// File: rtl/lsf_shift_in.sv
module lsf_shift_in #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sin,
  input  logic         lat,
  output logic [W-1:0] sr_q,
  output logic         sclk_rise,
  output logic         lat_fall,
  output logic         lat_lvl
);
  logic sclk_s, sclk_d, sin_s, lat_s, lat_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      sin_s  <= 1'b0;
      lat_s  <= 1'b0;
      lat_d  <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_s <= sclk;
      sclk_d <= sclk_s;
      sin_s  <= sin;
      lat_s  <= lat;
      lat_d  <= lat_s;
      if (sclk_rise) sr_q <= {sr_q[W-2:0], sin_s};
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign lat_fall  = lat_d & ~lat_s;
  assign lat_lvl   = lat_s;

  AST_SOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sr_q[W-1] == $past(sr_q[W-2])); // R2

endmodule

// File: rtl/lsf_cmd_count.sv
module lsf_cmd_count
  import lsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic lat_lvl,
  input  logic lat_fall,
  output logic gs_wr_ev,
  output logic gs_pub_ev,
  output logic fc_wr_ev
);
  localparam logic [LSF_CNT_W-1:0] CNT_MAX = '1;

  logic [LSF_CNT_W-1:0] cnt_q;
  lsf_cmd_e             cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (lat_fall) begin
      cnt_q <= '0;
    end else if (sclk_rise && lat_lvl && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    cmd       = lat_fall ? lsf_decode(cnt_q) : CMD_NONE;
    gs_pub_ev = (cmd == CMD_GS_PUBLISH) || (cmd == CMD_LINE_RESET);
    gs_wr_ev  = (cmd == CMD_GS_WRITE) || gs_pub_ev;
    fc_wr_ev  = (cmd == CMD_FC_WRITE);
  end

  AST_CMD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_wr_ev || fc_wr_ev) |-> lat_fall); // R4

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fall |=> cnt_q == '0); // R4

endmodule

// File: rtl/lsf_gs_store.sv
module lsf_gs_store #(
  parameter int CH     = 48,
  parameter int GROUPS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gs_wr_ev,
  input  logic                 gs_pub_ev,
  input  logic [CH-1:0]        word,
  output logic [CH*GROUPS-1:0] disp_q
);
  localparam int ADDR_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(GROUPS - 1);

  logic [CH-1:0]     stage_q [GROUPS];
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (gs_pub_ev) begin
      addr_q <= '0;
    end else if (gs_wr_ev) begin
      addr_q <= next_addr(addr_q);
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[g]         <= '0;
        disp_q[g*CH +: CH] <= '0;
      end else begin
        if (gs_wr_ev && addr_q == ADDR_W'(g)) stage_q[g] <= word;
        if (gs_pub_ev)
          disp_q[g*CH +: CH] <= (addr_q == ADDR_W'(g)) ? word : stage_q[g];
      end
    end
  end

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    gs_pub_ev |=> addr_q == '0); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_wr_ev && !gs_pub_ev) |=> addr_q == next_addr($past(addr_q))); // R5

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_pub_ev |=> $stable(disp_q)); // R10

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_wr_ev |=> $stable(addr_q)); // R9

endmodule

// File: rtl/lsf_fc_reg.sv
module lsf_fc_reg #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fc_wr_ev,
  input  logic [W-1:0] word,
  output logic [W-1:0] fc_q
);
  localparam logic [W-1:0] FC_RST = W'(lsf_pkg::lsf_fc_default());

  always_ff @(posedge clk) begin
    if (!rst_n)        fc_q <= FC_RST;
    else if (fc_wr_ev) fc_q <= word;
  end

  AST_FC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_wr_ev |=> $stable(fc_q)); // R9

  AST_FC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fc_wr_ev |=> fc_q == $past(word)); // R8

endmodule

// File: rtl/led_serial_front.sv
module led_serial_front #(
  parameter int CH      = 48,
  parameter int GS_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sin,
  input  logic                  lat,
  output logic                  sout,
  output logic [CH*GS_BITS-1:0] disp_data,
  output logic [CH-1:0]         fc_word
);
  localparam int GROUPS = GS_BITS;

  logic [CH-1:0] sr_q;
  logic          sclk_rise, lat_fall, lat_lvl;
  logic          gs_wr_ev, gs_pub_ev, fc_wr_ev;

  lsf_shift_in #(.W(CH)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .lat(lat),
    .sr_q(sr_q), .sclk_rise(sclk_rise), .lat_fall(lat_fall), .lat_lvl(lat_lvl)
  );

  lsf_cmd_count u_cmd (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .lat_lvl(lat_lvl),
    .lat_fall(lat_fall), .gs_wr_ev(gs_wr_ev), .gs_pub_ev(gs_pub_ev),
    .fc_wr_ev(fc_wr_ev)
  );

  lsf_gs_store #(.CH(CH), .GROUPS(GROUPS)) u_store (
    .clk(clk), .rst_n(rst_n), .gs_wr_ev(gs_wr_ev), .gs_pub_ev(gs_pub_ev),
    .word(sr_q), .disp_q(disp_data)
  );

  lsf_fc_reg #(.W(CH)) u_fc (
    .clk(clk), .rst_n(rst_n), .fc_wr_ev(fc_wr_ev), .word(sr_q), .fc_q(fc_word)
  );

  assign sout = sr_q[CH-1];

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(gs_wr_ev && fc_wr_ev)); // R4

endmodule

// File: tb/test_led_serial_front.sv
module test_led_serial_front;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         sin = 1'b0;
  logic         lat = 1'b0;
  logic         sout;
  logic [767:0] disp_data;
  logic [47:0]  fc_word;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [47:0]  m_stage [16];
  logic [767:0] m_disp;
  logic [47:0]  m_fc;
  int           m_addr;

  always #2.5 clk = ~clk;

  led_serial_front i_led_serial_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .lat(lat),
    .sout(sout), .disp_data(disp_data), .fc_word(fc_word)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check768(input string req, input logic [767:0] act, input logic [767:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift w MSB first; the last k edges occur with lat high.
  task automatic send(input logic [47:0] w, input int k);
    for (int i = 47; i >= 0; i--) begin
      sin = w[i];
      lat = (i < k);
      tick(2);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
    end
    tick(2);
    lat = 1'b0;
    sin = 1'b0;
    tick(5);
  endtask

  // Reference model of a command acting on word w with edge count k.
  task automatic model(input logic [47:0] w, input int k);
    int c;
    c = (k > 15) ? 15 : k;
    if (c == 1 || c == 3 || c == 7) begin
      m_stage[m_addr] = w;
      if (c == 1) m_addr = (m_addr == 15) ? 0 : m_addr + 1;
      else begin
        for (int g = 0; g < 16; g++) m_disp[g*48 +: 48] = m_stage[g];
        m_addr = 0;
      end
    end else if (c == 5) begin
      m_fc = w;
    end
  endtask

  task automatic cmd(input logic [47:0] w, input int k);
    send(w, k);
    model(w, k);
  endtask

  function automatic logic [47:0] pattern(input int n);
    return {16'(n * 16'h1111 + 16'h0101), 16'(16'hBEEF ^ n), 16'(n * 7 + 3)};
  endfunction

  task automatic t_reset();
    check48("R1 sout", {47'd0, sout}, 48'd0);
    check768("R1 disp_data", disp_data, '0);
    check48("R1 fc_word", fc_word, {18'd0, 9'h100, 9'h100, 9'h100, 3'd4});
  endtask

  task automatic t_shift();
    logic [47:0] a;
    a = 48'hC3A5_0F1E_9B27;
    send(a, 0);
    check48("R3 sout after 48 edges", {47'd0, sout}, {47'd0, a[47]});
    sin = 1'b0; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; tick(3);
    check48("R2 sout after one more shift", {47'd0, sout}, {47'd0, a[46]});
    sin = 1'b1; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; tick(3);
    check48("R2 sout after second shift", {47'd0, sout}, {47'd0, a[45]});
  endtask

  task automatic t_fc();
    logic [47:0] f;
    f = 48'h5A5A_1234_8765;
    cmd(f, 5);
    check48("R8 fc load", fc_word, m_fc);
    check768("R8 display untouched by fc load", disp_data, m_disp);
  endtask

  task automatic t_ignored();
    cmd(48'hFFFF_0000_FFFF, 2);
    cmd(48'h0F0F_0F0F_0F0F, 4);
    cmd(48'h1111_2222_3333, 6);
    cmd(48'h7777_8888_9999, 9);
    lat = 1'b1; tick(4); lat = 1'b0; tick(5);
    check48("R9 fc after ignored counts", fc_word, m_fc);
    check768("R9 display after ignored counts", disp_data, m_disp);
  endtask

  task automatic t_line();
    for (int g = 0; g < 15; g++) cmd(pattern(g), 1);
    check768("R10 display held during group writes", disp_data, m_disp);
    cmd(48'h0, 2); // ignored between writes, must not move the address (R9)
    cmd(pattern(15), 3);
    check768("R6 full line published", disp_data, m_disp);
    check48("R6 last group placement", disp_data[767:720], pattern(15));
    check48("R5 first group placement", disp_data[47:0], pattern(0));
  endtask

  task automatic t_wrap();
    for (int g = 0; g < 17; g++) cmd(pattern(40 + g), 1);
    check768("R10 display held across wrap", disp_data, m_disp);
    cmd(pattern(99), 7);
    check768("R7 line reset publishes", disp_data, m_disp);
    check48("R5 wrap overwrote group 0", disp_data[47:0], pattern(56));
    cmd(pattern(123), 3);
    check48("R6 address back at group 0", disp_data[47:0], pattern(123));
    check768("R6 second publish", disp_data, m_disp);
  endtask

  initial begin
    for (int g = 0; g < 16; g++) m_stage[g] = '0;
    m_disp = '0;
    m_fc   = {18'd0, 9'h100, 9'h100, 9'h100, 3'd4};
    m_addr = 0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_shift();
    t_fc();
    t_ignored();
    t_line();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule